// File: doc/BRIEF.md
# Program Sequencer with Skip and Return Stack

This block steers instruction flow for a small machine with 12-bit instruction words. It holds the program counter and issues the fetch address each cycle. The word it receives back belongs to the fetch of the previous cycle, so every cycle executes one word while the next one is already being fetched. Jumps, subroutine calls, returns, taken conditional skips and computed writes to the low program-counter byte all discard that prefetched word. The discarded word executes as a no-operation, so each of these transfers costs two cycles.

Calls save their return address in a two-entry hardware stack. A return restores the address from that stack. In the same cycle it raises a one-cycle strobe that loads an 8-bit literal from the instruction into the working register. A sleep instruction freezes the sequencer until the next reset. The arithmetic datapath and the memories are outside the block. The datapath supplies the tested bit value, the zero result of the increment and decrement forms, and the computed program-counter write.

Top module: `prog_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first update, fetch_addr is 0, exec_nop is 1, halted is 0, w_load is 0 and the return stack is empty.
- R2: An executing word that is not a control transfer, not a taken skip and not a sleep advances fetch_addr by one, and the next word executes normally (exec_nop 0).
- R3: A jump, instr[11:9] = 3'b101, loads instr[8:0] into fetch_addr in the next cycle and squashes the word fetched before it, so exec_nop is 1 for one cycle.
- R4: A call, instr[11:8] = 4'b1001, pushes the address of the word that follows it, loads the zero-extended instr[7:0] into fetch_addr and squashes the prefetched word.
- R5: A return, instr[11:8] = 4'b1000, pulses w_load for its one execute cycle with w_lit = instr[7:0], pops the stack into fetch_addr and squashes the prefetched word.
- R6: The bit-test skips (instr[11:8] = 4'b0110 skips when bit_val is 0, 4'b0111 skips when bit_val is 1) make the next word a no-operation while fetch_addr keeps advancing by one. When the condition fails, nothing is skipped.
- R7: The zero-test skips (instr[11:6] = 6'b001011 decrement, 6'b001111 increment) skip the next word when zero_res is 1 and behave as plain words when it is 0.
- R8: pcl_we during an executing word loads the zero-extended pcl_wdata into fetch_addr and squashes the prefetched word.
- R9: A squashed word has no effect: its opcode, bit_val, zero_res and pcl_we are all ignored, and fetch_addr advances by one.
- R10: The stack holds two entries. A third push drops the oldest entry, returns pop the newest entry first, and a pop of an empty stack yields address 0.
- R11: Sleep (instr = 12'h003) sets halted in the next cycle. From then until reset, fetch_addr holds, exec_nop is 1, w_load is 0, and incoming words and pcl_we are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr | input | 12 | Word fetched in the previous cycle, now executing |
| bit_val | input | 1 | Value of the bit selected by a bit-test word |
| zero_res | input | 1 | Zero result of an increment or decrement skip word |
| pcl_we | input | 1 | Datapath writes the low program-counter byte this cycle |
| pcl_wdata | input | 8 | Value written to the low program-counter byte |
| fetch_addr | output | PC_W (9) | Program-memory address to fetch |
| exec_nop | output | 1 | The current word is squashed or the sequencer is halted |
| w_load | output | 1 | Strobe that loads the return literal into the working register |
| w_lit | output | 8 | Literal carried by the executing word |
| halted | output | 1 | The sequencer is stopped by sleep |

## Verification
The bound checker covers every cycle. It checks that a jump or call lands on its encoded target with the following cycle squashed, and that a taken bit-test or zero-test skip squashes exactly one word while the address still steps by one. It checks that w_load appears only on an executing return with the matching literal, and that the halted state holds its address and stays in force. The stack ordering cannot be expressed as a simple property: overflow dropping the oldest entry and an empty pop landing on 0 are shown only by the bench's nested-call scenario. The same holds for the reset state, for squashed words that carry live skip conditions or control opcodes, and for a computed write arriving while halted.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int INSTR_W = 12;
  localparam int LIT_W   = 8;

  typedef enum logic [2:0] {
    CTL_SEQ,
    CTL_JUMP,
    CTL_CALL,
    CTL_RET,
    CTL_TST_CLR,
    CTL_TST_SET,
    CTL_TST_ZERO,
    CTL_HALT
  } ctl_e;

  // Classify an executing word; sleep is matched in full before prefixes.
  function automatic ctl_e classify(input logic [INSTR_W-1:0] w);
    ctl_e k;
    if (w == 12'h003)                                 k = CTL_HALT;
    else if (w[11:9] == 3'b101)                       k = CTL_JUMP;
    else if (w[11:8] == 4'b1001)                      k = CTL_CALL;
    else if (w[11:8] == 4'b1000)                      k = CTL_RET;
    else if (w[11:8] == 4'b0110)                      k = CTL_TST_CLR;
    else if (w[11:8] == 4'b0111)                      k = CTL_TST_SET;
    else if (w[11:9] == 3'b001 && w[7:6] == 2'b11)    k = CTL_TST_ZERO;
    else                                              k = CTL_SEQ;
    return k;
  endfunction

endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int PC_W = 9
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic               bit_val,
  input  logic               zero_res,
  output ctl_e               kind,
  output logic               skip_hit,
  output logic [PC_W-1:0]    target
);

  always_comb begin
    kind = classify(instr);
    unique case (kind)
      CTL_TST_CLR:  skip_hit = ~bit_val;
      CTL_TST_SET:  skip_hit = bit_val;
      CTL_TST_ZERO: skip_hit = zero_res;
      default:      skip_hit = 1'b0;
    endcase
    if (kind == CTL_JUMP) target = PC_W'(instr[8:0]);
    else                  target = PC_W'(instr[LIT_W-1:0]);
  end

endmodule

// File: rtl/seq_stack.sv
module seq_stack #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top
);

  localparam int BITS = W * DEPTH;

  logic [BITS-1:0] stk_q, stk_d;
  logic            stk_en;

  // Vacated slots fill with zero, so an empty pop yields address 0.
  always_comb begin
    stk_en = push | pop;
    stk_d  = stk_q;
    if (push)     stk_d = {stk_q[BITS-W-1:0], push_data};
    else if (pop) stk_d = {W'(0), stk_q[BITS-1:W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  assign top = stk_q[W-1:0];

endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import seq_pkg::*;
#(
  parameter int PC_W      = 9,
  parameter int STK_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [11:0]        instr,
  input  logic               bit_val,
  input  logic               zero_res,
  input  logic               pcl_we,
  input  logic [7:0]         pcl_wdata,
  output logic [PC_W-1:0]    fetch_addr,
  output logic               exec_nop,
  output logic               w_load,
  output logic [7:0]         w_lit,
  output logic               halted
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  ctl_e            kind;
  logic            skip_hit;
  logic [PC_W-1:0] target;

  seq_decode #(.PC_W(PC_W)) i_decode (
    .instr    (instr),
    .bit_val  (bit_val),
    .zero_res (zero_res),
    .kind     (kind),
    .skip_hit (skip_hit),
    .target   (target)
  );

  logic [PC_W-1:0] pc_q, pc_d, stk_top;
  logic            squash_q, squash_d;
  logic            halt_q, halt_d;
  logic            run_en, push, pop, ret_go;

  seq_stack #(.W(PC_W), .DEPTH(STK_DEPTH)) i_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .pop       (pop),
    .push_data (pc_q),
    .top       (stk_top)
  );

  // Next-state: one executing word per cycle unless squashed or halted.
  always_comb begin
    run_en   = ~halt_q;
    pc_d     = pc_q + 1'b1;
    squash_d = 1'b0;
    halt_d   = halt_q;
    push     = 1'b0;
    pop      = 1'b0;
    ret_go   = 1'b0;
    if (run_en && !squash_q) begin
      unique case (kind)
        CTL_JUMP: begin
          pc_d     = target;
          squash_d = 1'b1;
        end
        CTL_CALL: begin
          push     = 1'b1;
          pc_d     = target;
          squash_d = 1'b1;
        end
        CTL_RET: begin
          pop      = 1'b1;
          ret_go   = 1'b1;
          pc_d     = stk_top;
          squash_d = 1'b1;
        end
        CTL_HALT: begin
          halt_d = 1'b1;
          pc_d   = pc_q;
        end
        default: begin
          if (pcl_we) begin
            pc_d     = PC_W'(pcl_wdata);
            squash_d = 1'b1;
          end else if (skip_hit) begin
            squash_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q     <= '0;
      squash_q <= 1'b1;
      halt_q   <= 1'b0;
    end else if (run_en) begin
      pc_q     <= pc_d;
      squash_q <= squash_d;
      halt_q   <= halt_d;
    end
  end

  assign fetch_addr = pc_q;
  assign exec_nop   = squash_q | halt_q;
  assign w_load     = ret_go;
  assign w_lit      = instr[LIT_W-1:0];
  assign halted     = halt_q;

endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int PC_W = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     instr,
  input logic            bit_val,
  input logic            zero_res,
  input logic            pcl_we,
  input logic [PC_W-1:0] fetch_addr,
  input logic            exec_nop,
  input logic            w_load,
  input logic [7:0]      w_lit,
  input logic            halted
);

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_nop && instr[11:9] == 3'b101)
    |=> (exec_nop && fetch_addr == PC_W'($past(instr[8:0]))));

  assert_call_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_nop && instr[11:8] == 4'b1001)
    |=> (exec_nop && fetch_addr == PC_W'($past(instr[7:0]))));

  assert_ret_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |-> (!exec_nop && instr[11:8] == 4'b1000 && w_lit == instr[7:0]));

  assert_bit_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_nop && !pcl_we && instr[11:9] == 3'b011 && bit_val == instr[8])
    |=> (exec_nop && fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

  assert_zero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_nop && !pcl_we && instr[11:9] == 3'b001 && instr[7:6] == 2'b11 && zero_res)
    |=> (exec_nop && fetch_addr == PC_W'($past(fetch_addr) + 1'b1)));

  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(fetch_addr)));

  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (exec_nop && !w_load));

endmodule

bind prog_seq seq_chk #(.PC_W(PC_W)) i_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .bit_val    (bit_val),
  .zero_res   (zero_res),
  .pcl_we     (pcl_we),
  .fetch_addr (fetch_addr),
  .exec_nop   (exec_nop),
  .w_load     (w_load),
  .w_lit      (w_lit),
  .halted     (halted)
);

// File: tb/test_prog_seq.sv
`timescale 1ns/100ps
module test_prog_seq;

  localparam int PC_W = 9;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [11:0]     instr;
  logic            bit_val, zero_res, pcl_we;
  logic [7:0]      pcl_wdata;
  logic [PC_W-1:0] fetch_addr;
  logic            exec_nop, w_load, halted;
  logic [7:0]      w_lit;

  always #2.5 clk = ~clk;

  prog_seq #(.PC_W(PC_W), .STK_DEPTH(2)) i_prog_seq (
    .clk(clk), .rst_n(rst_n), .instr(instr), .bit_val(bit_val),
    .zero_res(zero_res), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata),
    .fetch_addr(fetch_addr), .exec_nop(exec_nop), .w_load(w_load),
    .w_lit(w_lit), .halted(halted)
  );

  logic [11:0] rom  [512];
  logic        bitv [512];
  logic        zerv [512];
  logic        pclw [512];
  logic [7:0]  pcld [512];

  typedef struct {
    logic [PC_W-1:0] a;
    logic            nop;
    logic            wl;
    logic [7:0]      lit;
    logic            h;
    string           tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // Driver side: queue the expected outputs of the current cycle.
  task automatic expect_cyc(input logic [PC_W-1:0] a, input logic nop,
                            input logic wl, input logic [7:0] lit,
                            input logic h, input string tag);
    exp_t e;
    e.a = a; e.nop = nop; e.wl = wl; e.lit = lit; e.h = h; e.tag = tag;
    q.push_back(e);
  endtask

  // Advance one clock; the memory returns the word at the address issued.
  task automatic tick();
    logic [PC_W-1:0] a;
    a = fetch_addr;
    @(posedge clk);
    #1;
    instr     = rom[a];
    bit_val   = bitv[a];
    zero_res  = zerv[a];
    pcl_we    = pclw[a];
    pcl_wdata = pcld[a];
  endtask

  task automatic step(input logic [PC_W-1:0] a, input logic nop,
                      input logic wl, input logic [7:0] lit,
                      input logic h, input string tag);
    expect_cyc(a, nop, wl, lit, h, tag);
    tick();
  endtask

  // Monitor side: compare away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (fetch_addr !== e.a || exec_nop !== e.nop || w_load !== e.wl ||
          halted !== e.h || (e.wl && w_lit !== e.lit)) begin
        errors++;
        $display("FAIL %s: fetch=%h nop=%b wl=%b lit=%h halt=%b expected fetch=%h nop=%b wl=%b lit=%h halt=%b",
                 e.tag, fetch_addr, exec_nop, w_load, w_lit, halted,
                 e.a, e.nop, e.wl, e.lit, e.h);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  task automatic clear_rom();
    for (int i = 0; i < 512; i++) begin
      rom[i] = 12'h000; bitv[i] = 1'b0; zerv[i] = 1'b0;
      pclw[i] = 1'b0; pcld[i] = 8'h00;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    instr = 12'h000; bit_val = 1'b0; zero_res = 1'b0;
    pcl_we = 1'b0; pcl_wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    expect_cyc(9'h000, 1'b1, 1'b0, 8'h00, 1'b0, "R1 reset held");
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    clear_rom();
    rom[9'h000] = 12'hC05;
    rom[9'h001] = 12'h910;                     // call 0x10
    rom[9'h002] = 12'hA20;                     // jump 0x20
    rom[9'h003] = 12'h97F;                     // squashed call
    rom[9'h010] = 12'h85A;                     // return, literal 5A
    rom[9'h011] = 12'hA3F;                     // squashed jump
    rom[9'h020] = 12'h600;                     // bit-clear test, bit 0 -> skip
    rom[9'h021] = 12'hC11;
    rom[9'h022] = 12'h700;                     // bit-set test, bit 0 -> no skip
    rom[9'h023] = 12'h3C0; zerv[9'h023] = 1'b1; // increment skip, zero -> skip
    rom[9'h024] = 12'h600;                     // squashed test that would skip
    rom[9'h025] = 12'h2C0;                     // decrement skip, nonzero
    rom[9'h026] = 12'hC22; pclw[9'h026] = 1'b1; pcld[9'h026] = 8'h40;
    rom[9'h027] = 12'hA00;                     // squashed jump
    rom[9'h040] = 12'h950;
    rom[9'h050] = 12'h960;
    rom[9'h051] = 12'h803;
    rom[9'h060] = 12'h970;
    rom[9'h061] = 12'h802;
    rom[9'h070] = 12'h801;
    rom[9'h071] = 12'hA00;

    do_reset();
    step(9'h000, 1, 0, 8'h00, 0, "R1 first cycle after release");
    step(9'h001, 0, 0, 8'h00, 0, "R2 sequential step");
    step(9'h002, 0, 0, 8'h00, 0, "R2 sequential step");
    step(9'h010, 1, 0, 8'h00, 0, "R4 call target");
    step(9'h011, 0, 1, 8'h5A, 0, "R5 return literal strobe");
    step(9'h002, 1, 0, 8'h00, 0, "R5 return address");
    step(9'h003, 0, 0, 8'h00, 0, "R9 squashed jump ignored");
    step(9'h020, 1, 0, 8'h00, 0, "R3 jump target");
    step(9'h021, 0, 0, 8'h00, 0, "R3 resume after squash");
    step(9'h022, 1, 0, 8'h00, 0, "R6 bit-clear skip taken");
    step(9'h023, 0, 0, 8'h00, 0, "R6 skipped word");
    step(9'h024, 0, 0, 8'h00, 0, "R6 bit-set skip not taken");
    step(9'h025, 1, 0, 8'h00, 0, "R7 increment skip taken");
    step(9'h026, 0, 0, 8'h00, 0, "R9 squashed skip ignored");
    step(9'h027, 0, 0, 8'h00, 0, "R7 decrement skip not taken");
    step(9'h040, 1, 0, 8'h00, 0, "R8 computed write target");
    step(9'h041, 0, 0, 8'h00, 0, "R9 squashed jump after write");
    step(9'h050, 1, 0, 8'h00, 0, "R4 nested call 1");
    step(9'h051, 0, 0, 8'h00, 0, "R4 nested call 1 resume");
    step(9'h060, 1, 0, 8'h00, 0, "R4 nested call 2");
    step(9'h061, 0, 0, 8'h00, 0, "R4 nested call 2 resume");
    step(9'h070, 1, 0, 8'h00, 0, "R10 third push");
    step(9'h071, 0, 1, 8'h01, 0, "R5 return literal 01");
    step(9'h061, 1, 0, 8'h00, 0, "R10 newest entry first");
    step(9'h062, 0, 1, 8'h02, 0, "R5 return literal 02");
    step(9'h051, 1, 0, 8'h00, 0, "R10 second entry");
    step(9'h052, 0, 1, 8'h03, 0, "R10 return from emptied stack");
    step(9'h000, 1, 0, 8'h00, 0, "R10 empty pop gives 0");
    step(9'h001, 0, 0, 8'h00, 0, "R2 sequential after wrap");

    // Sleep scenario
    clear_rom();
    rom[9'h000] = 12'hC05;
    rom[9'h001] = 12'h003;                     // sleep
    rom[9'h002] = 12'hA00; pclw[9'h002] = 1'b1; pcld[9'h002] = 8'h40;
    do_reset();
    step(9'h000, 1, 0, 8'h00, 0, "R1 after second reset");
    step(9'h001, 0, 0, 8'h00, 0, "R2 step before sleep");
    step(9'h002, 0, 0, 8'h00, 0, "R11 sleep executing");
    step(9'h002, 1, 0, 8'h00, 1, "R11 halted");
    step(9'h002, 1, 0, 8'h00, 1, "R11 jump and write ignored while halted");
    step(9'h002, 1, 0, 8'h00, 1, "R11 still halted");
    step(9'h002, 1, 0, 8'h00, 1, "R11 still halted");
    rst_n = 1'b0;
    #1;
    expect_cyc(9'h000, 1'b1, 1'b0, 8'h00, 1'b0, "R1 reset leaves halt");
    @(negedge clk);
    #1;
    finish_run();
  end

endmodule